// File: doc/BRIEF.md
# PCI burst byte-enable sequencer

This block sits on the initiator side of a 32-bit PCI interface and owns the C/BE# lines. In the address phase it passes a bus command through to them. During the data phases that follow it drives one active-low byte-lane mask per phase. The masks come from a small local FIFO that the initiator's control logic fills ahead of time. Any 4-bit pattern is accepted, including non-contiguous ones, and on reads as well as writes. The mask may change from one phase to the next.

The sequencer watches IRDY# and TRDY# to find the edge on which each data phase completes. It holds the current mask unchanged through every wait state. It moves to the next mask only on the clock after a completion. When a completion happens with FRAME# deasserted, the burst is over and the output enable is dropped. If no mask is queued when a phase begins, the phase is driven with every lane disabled and an underrun flag is raised.

Top module: `be_burst_seq`

## Requirements
- R1: While no burst is in progress and `frame_n` is low, `cbe_oe` is 1 and `cbe_n` equals `bus_cmd` in the same cycle. This is the address phase.
- R2: On the clock after the address phase, the sequencer enters the first data phase, keeps `cbe_oe` at 1 and drives `cbe_n` with the oldest queued mask.
- R3: During a data phase, `cbe_n` does not change on any edge where `irdy_n` or `trdy_n` is sampled high (a wait state).
- R4: A data phase completes on a rising edge where `irdy_n` and `trdy_n` are both sampled low. If `frame_n` is low on that edge, the next mask appears on `cbe_n` in the cycle after it. Every 4-bit value, contiguous or not, is driven exactly as queued.
- R5: Exactly one queued mask is consumed per completed phase, so masks appear in the order they were pushed and none is skipped or repeated.
- R6: If the queue holds no mask when a data phase begins, that phase drives `cbe_n` = 4'b1111 and `underrun` = 1 for its whole length, and it consumes nothing from the queue.
- R7: After a completion edge with `frame_n` high, the next cycle has `cbe_oe` = 0 and `cbe_n` = 4'b1111, unless `frame_n` is low again.
- R8: Synchronous active-high `rst` empties the queue, ends any burst and forces `cbe_oe` = 0 and `underrun` = 0.
- R9: The queue holds `DEPTH` masks (8 by default) and `q_full` is 1 when it holds that many. A push while full is dropped and is never driven.
- R10: If the queue is empty but `mask_push` is high on the edge where a phase begins, the pushed mask is used for that phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME# as sampled from the bus, active low |
| irdy_n | input | 1 | IRDY# as sampled, active low |
| trdy_n | input | 1 | TRDY# as sampled, active low |
| bus_cmd | input | LANES | Command code driven during the address phase |
| mask_push | input | 1 | Pushes `mask_data` into the mask queue |
| mask_data | input | LANES | Active-low byte-lane mask for a later data phase |
| cbe_n | output | LANES | Value for the C/BE# lines |
| cbe_oe | output | 1 | Output enable for the C/BE# drivers |
| underrun | output | 1 | Current data phase had no queued mask |
| q_full | output | 1 | Mask queue is full |

## Verification
Bursts are run with no wait states, with long runs of mixed IRDY#/TRDY# waits, and with single-phase lengths. This separates mask stability from mask advance: a design that advances on either ready alone fails in the wait-state runs. Non-contiguous and all-enabled masks are queued in a known order, so a skipped or repeated pop is visible. Queue depths of zero, one short of the burst, and over-full exercise the underrun, bypass and drop paths. A random mix of all of these, with pushes landing on phase-start edges, is compared cycle by cycle against a behavioural queue model in the bench.

// File: rtl/be_seq_pkg.sv
package be_seq_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } ph_state_t;

  // A data phase ends on an edge where both ready strobes are low.
  function automatic logic phase_complete(input logic irdy_n, input logic trdy_n);
    return (!irdy_n) && (!trdy_n);
  endfunction

  // How many queued entries are consumed on this edge.
  function automatic int unsigned consumed(input logic pop);
    return pop ? 1 : 0;
  endfunction

endpackage

// File: rtl/be_mask_queue.sv
module be_mask_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic          push_ok,
  output logic          full,
  output logic [CW-1:0] level,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1
);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign level   = cnt;
  assign head0   = store[rd_ptr];
  assign head1   = store[wrap_inc(rd_ptr)];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)     rd_ptr <= wrap_inc(rd_ptr);
      cnt <= cnt + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  // R5: a pop never meets an empty queue
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));

  // R9: occupancy never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R9: a push against a full queue without a pop leaves it full and unchanged
  a_r9_full_drops: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/be_phase_fsm.sv
module be_phase_fsm
  import be_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic underrun_q,
  output logic in_data,
  output logic addr_phase,
  output logic start,
  output logic done,
  output logic last,
  output logic load,
  output logic pop
);

  ph_state_t state;
  ph_state_t state_nx;

  assign in_data    = (state == PH_DATA);
  assign addr_phase = (state == PH_IDLE) && !frame_n;
  assign start      = addr_phase;
  assign done       = in_data && phase_complete(irdy_n, trdy_n);
  assign last       = done && frame_n;
  assign load       = start || (done && !frame_n);
  assign pop        = done && !underrun_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE: if (start) state_nx = PH_DATA;
      PH_DATA: if (last)  state_nx = PH_IDLE;
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_IDLE;
    else     state <= state_nx;
  end

  // R2: an address phase is always followed by a data phase
  a_r2_enter_data: assert property (@(posedge clk) disable iff (rst)
    start |=> in_data);

  // R7: the burst ends after a completion with FRAME# high
  a_r7_leave_data: assert property (@(posedge clk) disable iff (rst)
    last |=> !in_data);

endmodule

// File: rtl/be_mask_hold.sv
module be_mask_hold #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          pop,
  input  logic [CW-1:0] level,
  input  logic [W-1:0]  head0,
  input  logic [W-1:0]  head1,
  input  logic          push_ok,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  mask_q,
  output logic          underrun_q
);

  logic [W-1:0] mask_nx;
  logic         under_nx;

  // Entry that becomes the head once this edge's pop has been applied,
  // falling back to a same-edge push, then to an all-disabled mask.
  always_comb begin
    if (level > CW'(be_seq_pkg::consumed(pop))) begin
      mask_nx  = pop ? head1 : head0;
      under_nx = 1'b0;
    end else if (push_ok) begin
      mask_nx  = push_data;
      under_nx = 1'b0;
    end else begin
      mask_nx  = '1;
      under_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '1;
      underrun_q <= 1'b0;
    end else if (load) begin
      mask_q     <= mask_nx;
      underrun_q <= under_nx;
    end
  end

  // R6: an underrun phase never enables a lane
  a_r6_underrun_blank: assert property (@(posedge clk) disable iff (rst)
    underrun_q |-> (mask_q == '1));

endmodule

// File: rtl/be_burst_seq.sv
module be_burst_seq #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [LANES-1:0] bus_cmd,
  input  logic             mask_push,
  input  logic [LANES-1:0] mask_data,
  output logic [LANES-1:0] cbe_n,
  output logic             cbe_oe,
  output logic             underrun,
  output logic             q_full
);

  logic             in_data, addr_phase, start, done, last, load, pop;
  logic             push_ok, underrun_q;
  logic [CW-1:0]    level;
  logic [LANES-1:0] head0, head1, mask_q;

  be_mask_queue #(.DEPTH(DEPTH), .W(LANES)) i_queue (
    .clk(clk), .rst(rst), .push(mask_push), .push_data(mask_data), .pop(pop),
    .push_ok(push_ok), .full(q_full), .level(level), .head0(head0), .head1(head1)
  );

  be_phase_fsm i_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .underrun_q(underrun_q), .in_data(in_data), .addr_phase(addr_phase),
    .start(start), .done(done), .last(last), .load(load), .pop(pop)
  );

  be_mask_hold #(.DEPTH(DEPTH), .W(LANES)) i_hold (
    .clk(clk), .rst(rst), .load(load), .pop(pop), .level(level),
    .head0(head0), .head1(head1), .push_ok(push_ok), .push_data(mask_data),
    .mask_q(mask_q), .underrun_q(underrun_q)
  );

  assign cbe_oe   = !rst && (in_data || addr_phase);
  assign underrun = in_data && underrun_q;

  always_comb begin
    if (in_data)         cbe_n = mask_q;
    else if (addr_phase) cbe_n = bus_cmd;
    else                 cbe_n = '1;
  end

  // R3: wait states leave the lines untouched
  a_r3_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    (in_data && !done) |=> $stable(cbe_n));

  // R4: within a burst the lines only move after a completion edge
  a_r4_move_after_done: assert property (@(posedge clk) disable iff (rst)
    (in_data && $past(in_data) && (cbe_n != $past(cbe_n))) |-> $past(done));

  // R7: after the final phase the drivers are released
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (last && !start) |=> (frame_n || cbe_oe) && (!frame_n || !cbe_oe));

  // R8: reset empties the burst state on the next cycle
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> !in_data);

  always_comb begin
    if (rst) a_r8_no_drive: assert (!cbe_oe);
  end

endmodule

// File: tb/test_be_burst_seq.sv
module test_be_burst_seq;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_n, irdy_n, trdy_n, mask_push;
  logic [3:0] bus_cmd, mask_data;
  logic [3:0] cbe_n;
  logic       cbe_oe, underrun, q_full;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model of the requirements
  logic [3:0] mq[$];
  bit         m_in;
  logic [3:0] m_mask;
  bit         m_und;

  be_burst_seq #(.DEPTH(DEPTH), .LANES(4)) i_be_burst_seq (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .bus_cmd(bus_cmd), .mask_push(mask_push), .mask_data(mask_data),
    .cbe_n(cbe_n), .cbe_oe(cbe_oe), .underrun(underrun), .q_full(q_full)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    mq.delete();
    m_in   = 0;
    m_mask = 4'hF;
    m_und  = 0;
  endfunction

  // R2/R5/R6/R10: mask selected when a phase begins
  function automatic void model_pick();
    if (mq.size() > 0) begin
      m_mask = mq[0];
      m_und  = 0;
    end else begin
      m_mask = 4'hF;
      m_und  = 1;
    end
  endfunction

  task automatic cyc(string tag, bit fr, bit ir, bit tr, bit pu, logic [3:0] pd);
    bit exp_oe, st, dn, acc;
    logic [3:0] exp_cbe;
    @(negedge clk);
    frame_n = fr; irdy_n = ir; trdy_n = tr; mask_push = pu; mask_data = pd;
    bus_cmd = 4'(($urandom % 16));
    #2;
    exp_oe  = m_in ? 1'b1 : !fr;
    exp_cbe = m_in ? m_mask : (!fr ? bus_cmd : 4'hF);
    check(tag, "cbe_oe",   8'(cbe_oe),   8'(exp_oe));
    check(tag, "cbe_n",    8'(cbe_n),    8'(exp_cbe));
    check(tag, "underrun", 8'(underrun), 8'(m_in && m_und));
    check({tag, " R9"}, "q_full", 8'(q_full), 8'(mq.size() == DEPTH));
    @(posedge clk);
    #1;
    st  = !m_in && !fr;
    dn  = m_in && !ir && !tr;
    acc = pu && (mq.size() < DEPTH);
    if (dn && !m_und) void'(mq.pop_front());
    if (acc) mq.push_back(pd);
    if (st || (dn && !fr)) begin
      model_pick();
      m_in = 1;
    end
    if (dn && fr) m_in = 0;
  endtask

  task automatic fill(string tag, int k);
    for (int i = 0; i < k; i++) cyc(tag, 1, 1, 1, 1, 4'(($urandom % 16)));
  endtask

  task automatic fill_list(string tag, logic [15:0] vals, int k);
    for (int i = 0; i < k; i++) cyc(tag, 1, 1, 1, 1, vals[4*i +: 4]);
  endtask

  task automatic burst(string tag, int n, int maxwait, bit rpush);
    cyc({tag, " R1"}, 0, 1, 1, rpush && ($urandom % 3 == 0), 4'(($urandom % 16)));
    for (int i = 0; i < n; i++) begin
      int w;
      w = (maxwait > 0) ? int'($urandom_range(maxwait)) : 0;
      for (int j = 0; j < w; j++) begin
        bit ir, tr;
        ir = 1'($urandom % 2);
        tr = ir ? 1'($urandom % 2) : 1'b1;
        cyc({tag, " R3"}, 0, ir, tr, rpush && ($urandom % 3 == 0), 4'(($urandom % 16)));
      end
      cyc({tag, " R4"}, (i == n - 1), 0, 0, rpush && ($urandom % 3 == 0), 4'(($urandom % 16)));
    end
    cyc({tag, " R7"}, 1, 1, 1, 0, 4'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; frame_n = 1; irdy_n = 1; trdy_n = 1; mask_push = 0; mask_data = 0; bus_cmd = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    do_reset();
    // R8: quiet outputs and empty queue after reset
    cyc("R8 reset", 1, 1, 1, 0, 4'h0);
    burst("R8 empty after reset", 1, 0, 0);

    // R1/R2: address phase then first queued mask
    fill_list("R2", 16'h00C5, 2);
    burst("R1/R2 first mask", 2, 0, 0);

    // R3: long waits between completions
    fill("R3", 3);
    burst("R3 hold in waits", 3, 4, 0);

    // R4/R5: non-contiguous patterns back to back, in push order
    fill_list("R5", 16'h065A, 4);
    burst("R4/R5 order", 4, 0, 0);

    // R6: one mask for a three-phase burst
    fill_list("R6", 16'h0003, 1);
    burst("R6 underrun", 3, 1, 0);

    // R9: overfill, ninth phase must underrun
    fill("R9 overfill", 10);
    burst("R9 dropped push", 9, 0, 0);

    // R10: push on the address-phase edge with an empty queue
    cyc("R10 bypass", 0, 1, 1, 1, 4'h9);
    cyc("R10 bypass", 1, 0, 0, 0, 4'h0);
    cyc("R10 bypass R7", 1, 1, 1, 0, 4'h0);

    // R8: reset in the middle of a burst
    fill("R8", 3);
    cyc("R8", 0, 1, 1, 0, 4'h0);
    cyc("R8", 0, 1, 0, 0, 4'h0);
    do_reset();
    cyc("R8 mid-burst reset", 1, 1, 1, 0, 4'h0);
    burst("R8 queue cleared", 1, 0, 0);

    // random mix
    for (int b = 0; b < 200; b++) begin
      if ($urandom % 2 == 0) fill("random fill", int'($urandom_range(6)));
      burst("random", 1 + int'($urandom_range(5)), 3, 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule